// File: doc/BRIEF.md
# Half-Bridge Gate Drive Sequencer

This block sits between a leg-state command and the two gate drivers of one half-bridge. A two-bit request asks for the high FET on, the low FET on, or both off. The block drives an enable for each FET and a strength select for each driver, where 1 selects peak drive and 0 selects hold drive. The request is first filtered, so that a short glitch on the command never reaches the gates.

Every transition is break-before-make. The FET being switched off gets its enable removed at once. It is then given a turn-off window at peak sink strength, and that window confirms the FET is off. A digital dead time follows, and only after it does the opposite FET receive its enable. Each turn-on applies peak strength for a fixed window and then falls back to hold strength. While the high FET is in its turn-on window, the low gate is held with a strong pull-down. The final cycle of every completed drive window is flagged on a separate output, so that a neighbouring fault checker can sample the gate voltages there.

Top module: `hb_gate_seq`

## Requirements
- R1: Command encoding on `leg_cmd` is 2'b10 for the high FET on, 2'b01 for the low FET on, and 2'b00 or 2'b11 for both off. While `rst_n` is low, and right after reset, all six outputs are 0.
- R2: A new command value takes effect only after it has been sampled on DGL_CYC consecutive rising edges. A value held for fewer samples changes no output.
- R3: `hs_en` and `ls_en` are never 1 in the same cycle.
- R4: An enable rises only after the off phase has run in full: DRV_CYC cycles of turn-off window, then DEAD_CYC cycles of dead time. Starting from the idle state, only the DEAD_CYC dead time is needed.
- R5: Once a changed command has been accepted, the enable of the FET that was on drops on the very next rising edge, with no dead-time wait. This holds whether the new command is off or the opposite FET.
- R6: While a FET is enabled, its peak select is 1 for the first DRV_CYC cycles and 0 after that.
- R7: The peak select of the FET just switched off is 1 for DRV_CYC cycles, starting in the cycle its enable drops. During that window both enables are 0.
- R8: `ls_pulldown` is 1 exactly during the first DRV_CYC cycles of `hs_en` being 1, and 0 at all other times.
- R9: `drive_win_end` is 1 for one cycle: the last cycle of each turn-on or turn-off window that runs its full length.
- R10: A command change that is accepted during a turn-on window cuts the window short. The FET is switched off and its turn-off window starts. The cut window produces no `drive_win_end` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| leg_cmd | input | 2 | Requested leg state (see R1) |
| hs_en | output | 1 | High-side FET enable |
| hs_peak | output | 1 | High-side driver strength: 1 peak, 0 hold |
| ls_en | output | 1 | Low-side FET enable |
| ls_peak | output | 1 | Low-side driver strength: 1 peak, 0 hold |
| ls_pulldown | output | 1 | Strong pull-down on the low gate during high-side turn-on |
| drive_win_end | output | 1 | One-cycle flag on the last cycle of a completed drive window |

## Verification
Two functions can fall in the same cycle: the end of a turn-on window, and the acceptance of a new command that switches the FET off. A command change is released so that it is accepted a few cycles into the turn-on window. The bench then checks that the drive window is cut and yields no end flag, and that exactly one flag, for the turn-off window, appears afterwards. A long pseudo-random command sequence pushes the same collision to many different offsets. On every cycle, each output is compared with a behavioural model that tracks the phase and how long it has lasted.

// File: rtl/gs_pkg.sv
package gs_pkg;

   typedef enum logic [1:0] {
      CMD_OFF   = 2'b00,
      CMD_LOW   = 2'b01,
      CMD_HIGH  = 2'b10,
      CMD_OFF_B = 2'b11
   } leg_cmd_e;

   typedef enum logic [1:0] {
      ST_IDLE   = 2'd0,
      ST_SETTLE = 2'd1,
      ST_DEAD   = 2'd2,
      ST_ON     = 2'd3
   } seq_st_e;

   localparam int SIDE_LS = 0;
   localparam int SIDE_HS = 1;

   function automatic logic cmd_drives(input logic [1:0] c);
      return (c == CMD_LOW) || (c == CMD_HIGH);
   endfunction

   function automatic logic cmd_is_high(input logic [1:0] c);
      return (c == CMD_HIGH);
   endfunction

endpackage

// File: rtl/gs_deglitch.sv
module gs_deglitch #(
   parameter int W   = 2,
   parameter int DGL = 3
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] raw,
   output logic [W-1:0] filt
);
   localparam int DW = $clog2(DGL + 1);

   generate
      if (DGL < 1) begin : g_bad_dgl
         $error("gs_deglitch: DGL must be at least 1");
      end

      if (DGL == 1) begin : g_direct
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) filt <= '0;
            else        filt <= raw;
         end
      end else begin : g_count
         logic [W-1:0]  cand;
         logic [DW-1:0] run;
         logic          steady;

         assign steady = (raw == cand) && (run >= DW'(DGL - 1));

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               cand <= '0;
               run  <= DW'(DGL);
               filt <= '0;
            end else begin
               if (raw != cand) begin
                  cand <= raw;
                  run  <= DW'(1);
               end else if (run != DW'(DGL)) begin
                  run <= run + DW'(1);
               end
               if (steady) filt <= raw;
            end
         end

         // R2: the filtered value only changes to a value equal to the candidate being timed
         p_filt_from_cand_r2 : assert property (@(posedge clk) disable iff (!rst_n)
            (filt != $past(filt)) |-> (filt == $past(cand)));
      end
   endgenerate

endmodule

// File: rtl/gs_seq_core.sv
module gs_seq_core
   import gs_pkg::*;
#(
   parameter int DRV_CYC  = 8,
   parameter int DEAD_CYC = 15
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [1:0] cmd,
   output logic [1:0] on_act,
   output logic       on_win,
   output logic       off_win,
   output logic       off_side,
   output logic       win_end
);
   localparam int MAXC = (DRV_CYC > DEAD_CYC) ? DRV_CYC : DEAD_CYC;
   localparam int CW   = $clog2(MAXC + 1);

   generate
      if (DRV_CYC < 2) begin : g_bad_drv
         $error("gs_seq_core: DRV_CYC must be at least 2");
      end
      if (DEAD_CYC < 1) begin : g_bad_dead
         $error("gs_seq_core: DEAD_CYC must be at least 1");
      end
   endgenerate

   seq_st_e        st, st_n;
   logic           side_q, side_n;
   logic [CW-1:0]  cnt, cnt_n;
   logic           want, want_hi, match;
   logic           drv_last, dead_last;

   assign want      = cmd_drives(cmd);
   assign want_hi   = cmd_is_high(cmd);
   assign match     = want && (want_hi == side_q);
   assign drv_last  = (cnt == CW'(DRV_CYC - 1));
   assign dead_last = (cnt == CW'(DEAD_CYC - 1));

   always_comb begin
      st_n   = st;
      side_n = side_q;
      cnt_n  = cnt;
      unique case (st)
         ST_IDLE: begin
            if (want) begin
               st_n  = ST_DEAD;
               cnt_n = '0;
            end
         end
         ST_SETTLE: begin
            if (drv_last) begin
               st_n  = want ? ST_DEAD : ST_IDLE;
               cnt_n = '0;
            end else begin
               cnt_n = cnt + CW'(1);
            end
         end
         ST_DEAD: begin
            if (dead_last) begin
               cnt_n = '0;
               if (want) begin
                  st_n   = ST_ON;
                  side_n = want_hi;
               end else begin
                  st_n = ST_IDLE;
               end
            end else begin
               cnt_n = cnt + CW'(1);
            end
         end
         ST_ON: begin
            if (!match) begin
               st_n  = ST_SETTLE;
               cnt_n = '0;
            end else if (cnt != CW'(DRV_CYC)) begin
               cnt_n = cnt + CW'(1);
            end
         end
         default: begin
            st_n  = ST_IDLE;
            cnt_n = '0;
         end
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st     <= ST_IDLE;
         side_q <= 1'b0;
         cnt    <= '0;
      end else begin
         st     <= st_n;
         side_q <= side_n;
         cnt    <= cnt_n;
      end
   end

   assign on_act[SIDE_HS] = (st == ST_ON) &&  side_q;
   assign on_act[SIDE_LS] = (st == ST_ON) && !side_q;
   assign on_win          = (st == ST_ON) && (cnt < CW'(DRV_CYC));
   assign off_win         = (st == ST_SETTLE);
   assign off_side        = side_q;
   assign win_end         = ((st == ST_ON) || (st == ST_SETTLE)) && drv_last;

   // R9: a window end is never followed by another window end in the next cycle
   p_win_end_single_r9 : assert property (@(posedge clk) disable iff (!rst_n)
      win_end |=> !win_end);

   // R10: when the command stops matching the FET that is on, the next cycle is a turn-off window
   p_abort_to_off_r10 : assert property (@(posedge clk) disable iff (!rst_n)
      ((on_act != 2'b00) && !match) |=> (off_win && (on_act == 2'b00)));

endmodule

// File: rtl/gs_side_drive.sv
module gs_side_drive #(
   parameter int SIDE = 0
) (
   input  logic on_act,
   input  logic on_win,
   input  logic off_win,
   input  logic off_side,
   output logic en,
   output logic peak
);
   localparam logic SIDE_BIT = (SIDE != 0);

   generate
      if ((SIDE != 0) && (SIDE != 1)) begin : g_bad_side
         $error("gs_side_drive: SIDE must be 0 or 1");
      end
   endgenerate

   assign en   = on_act;
   assign peak = (on_act && on_win) || (off_win && (off_side == SIDE_BIT));

endmodule

// File: rtl/hb_gate_seq.sv
module hb_gate_seq
   import gs_pkg::*;
#(
   parameter int DRV_CYC  = 8,
   parameter int DEAD_CYC = 15,
   parameter int DGL_CYC  = 3
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [1:0] leg_cmd,
   output logic       hs_en,
   output logic       hs_peak,
   output logic       ls_en,
   output logic       ls_peak,
   output logic       ls_pulldown,
   output logic       drive_win_end
);
   localparam int GAP_MAX = DRV_CYC + DEAD_CYC;
   localparam int GW      = $clog2(GAP_MAX + 1);

   logic [1:0] cmd_f;
   logic [1:0] on_act;
   logic       on_win, off_win, off_side;
   logic [1:0] en_v, pk_v;

   gs_deglitch #(.W(2), .DGL(DGL_CYC)) u_dgl (
      .clk  (clk),
      .rst_n(rst_n),
      .raw  (leg_cmd),
      .filt (cmd_f)
   );

   gs_seq_core #(.DRV_CYC(DRV_CYC), .DEAD_CYC(DEAD_CYC)) u_core (
      .clk     (clk),
      .rst_n   (rst_n),
      .cmd     (cmd_f),
      .on_act  (on_act),
      .on_win  (on_win),
      .off_win (off_win),
      .off_side(off_side),
      .win_end (drive_win_end)
   );

   generate
      for (genvar s = 0; s < 2; s++) begin : g_side
         gs_side_drive #(.SIDE(s)) u_drv (
            .on_act  (on_act[s]),
            .on_win  (on_win),
            .off_win (off_win),
            .off_side(off_side),
            .en      (en_v[s]),
            .peak    (pk_v[s])
         );
      end
   endgenerate

   assign hs_en       = en_v[SIDE_HS];
   assign ls_en       = en_v[SIDE_LS];
   assign hs_peak     = pk_v[SIDE_HS];
   assign ls_peak     = pk_v[SIDE_LS];
   assign ls_pulldown = on_act[SIDE_HS] && on_win;

   // Cycles since either enable was last high, saturating; used to check the break-before-make gap
   logic [GW-1:0] gap;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  gap <= GW'(GAP_MAX);
      else if (hs_en || ls_en)     gap <= '0;
      else if (gap != GW'(GAP_MAX)) gap <= gap + GW'(1);
   end

   // R3: the two enables never overlap
   p_no_overlap_r3 : assert property (@(posedge clk) disable iff (!rst_n)
      !(hs_en && ls_en));

   // R4: any enable rise comes after at least the turn-off window plus the dead time
   p_gap_before_on_r4 : assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(hs_en) || $rose(ls_en)) |-> (gap >= GW'(GAP_MAX)));

   // R7: a FET that has just been switched off is sunk at peak strength
   p_off_peak_hs_r7 : assert property (@(posedge clk) disable iff (!rst_n)
      $fell(hs_en) |-> (hs_peak && !ls_en));
   p_off_peak_ls_r7 : assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ls_en) |-> (ls_peak && !hs_en));

   // R8: the strong low-gate pull-down appears only while the high FET is on at peak strength
   p_pulldown_r8 : assert property (@(posedge clk) disable iff (!rst_n)
      ls_pulldown |-> (hs_en && hs_peak && !ls_en && !ls_peak));

   // R9: a window-end flag marks a cycle in which some driver is at peak strength
   p_win_end_peak_r9 : assert property (@(posedge clk) disable iff (!rst_n)
      drive_win_end |-> (hs_peak || ls_peak));

endmodule

// File: tb/hb_gate_seq_tb_top.sv
module hb_gate_seq_tb_top;
   localparam int DRV  = 8;
   localparam int DEAD = 15;
   localparam int DGL  = 3;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] cmd = 2'b00;
   logic       hs_en, hs_peak, ls_en, ls_peak, ls_pulldown, drive_win_end;

   hb_gate_seq #(.DRV_CYC(DRV), .DEAD_CYC(DEAD), .DGL_CYC(DGL)) dut_i (
      .clk          (clk),
      .rst_n        (rst_n),
      .leg_cmd      (cmd),
      .hs_en        (hs_en),
      .hs_peak      (hs_peak),
      .ls_en        (ls_en),
      .ls_peak      (ls_peak),
      .ls_pulldown  (ls_pulldown),
      .drive_win_end(drive_win_end)
   );

   always #2 clk = ~clk;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 0;
   int we_cnt = 0;

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
      end
   endtask

   // Behavioural reference: phase 0 idle, 1 turn-off window, 2 dead time, 3 FET on
   int m_phase = 0;
   int m_hi    = 0;
   int m_age   = 0;
   int acc     = 0;
   int run_v   = 0;
   int run_n   = DGL;

   function automatic int drives(input int c);
      return (c == 1 || c == 2) ? 1 : 0;
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_phase = 0; m_hi = 0; m_age = 0; acc = 0; run_v = 0; run_n = DGL;
      end else begin
         case (m_phase)
            0: if (drives(acc) != 0) begin m_phase = 2; m_age = 0; end
            1: if (m_age == DRV - 1) begin
                  m_phase = (drives(acc) != 0) ? 2 : 0; m_age = 0;
               end else m_age++;
            2: if (m_age == DEAD - 1) begin
                  m_age = 0;
                  if (drives(acc) != 0) begin m_phase = 3; m_hi = (acc == 2); end
                  else m_phase = 0;
               end else m_age++;
            default: begin
               if (drives(acc) == 0 || (acc == 2) != (m_hi != 0)) begin
                  m_phase = 1; m_age = 0;
               end else if (m_age < DRV) m_age++;
            end
         endcase
         if (int'(cmd) == run_v) begin
            if (run_n < 100000) run_n++;
         end else begin
            run_v = int'(cmd); run_n = 1;
         end
         if (run_n >= DGL) acc = run_v;
      end
   end

   always @(negedge clk) begin
      if (rst_n) begin
         int e_hs, e_ls, e_hp, e_lp, e_pd, e_we;
         e_hs = (m_phase == 3 && m_hi != 0);
         e_ls = (m_phase == 3 && m_hi == 0);
         e_hp = (e_hs && m_age < DRV) || (m_phase == 1 && m_hi != 0);
         e_lp = (e_ls && m_age < DRV) || (m_phase == 1 && m_hi == 0);
         e_pd = (e_hs && m_age < DRV);
         e_we = ((m_phase == 3 || m_phase == 1) && m_age == DRV - 1);
         check(int'(hs_en) == e_hs, "R4 R5 hs_en", int'(hs_en), e_hs);
         check(int'(ls_en) == e_ls, "R4 R5 ls_en", int'(ls_en), e_ls);
         check(int'(hs_peak) == e_hp, "R6 R7 R10 hs_peak", int'(hs_peak), e_hp);
         check(int'(ls_peak) == e_lp, "R6 R7 R10 ls_peak", int'(ls_peak), e_lp);
         check(int'(ls_pulldown) == e_pd, "R8 ls_pulldown", int'(ls_pulldown), e_pd);
         check(int'(drive_win_end) == e_we, "R9 R10 drive_win_end", int'(drive_win_end), e_we);
         check(!(hs_en && ls_en), "R3 overlap", int'(hs_en && ls_en), 0);
         if (drive_win_end) we_cnt++;
      end
   end

   task automatic hold(input logic [1:0] c, input int n);
      cmd = c;
      repeat (n) @(negedge clk);
   endtask

   initial begin
      #600000;
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog expired");
         $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      logic [15:0] lf;
      int w0;
      repeat (4) @(negedge clk);
      check({hs_en, ls_en, hs_peak, ls_peak, ls_pulldown, drive_win_end} == 6'b0,
            "R1 outputs in reset", int'({hs_en, ls_en, hs_peak, ls_peak, ls_pulldown, drive_win_end}), 0);
      rst_n = 1'b1;
      @(negedge clk);
      check({hs_en, ls_en, hs_peak, ls_peak, ls_pulldown, drive_win_end} == 6'b0,
            "R1 outputs after reset", int'({hs_en, ls_en, hs_peak, ls_peak, ls_pulldown, drive_win_end}), 0);

      // R1: code 11 behaves as off
      hold(2'b11, 40);
      check(!hs_en && !ls_en, "R1 code 11 is off", int'({hs_en, ls_en}), 0);

      // high on from idle, then full switch to low
      hold(2'b10, 50);
      check(hs_en == 1'b1 && hs_peak == 1'b0, "R6 high held at hold strength", int'({hs_en, hs_peak}), 2);
      hold(2'b01, 60);
      check(ls_en == 1'b1 && !hs_en, "R4 low on after full switch", int'({hs_en, ls_en}), 1);

      // R2: a glitch shorter than the filter is ignored
      hold(2'b10, DGL - 1);
      hold(2'b01, 12);
      check(ls_en == 1'b1 && hs_en == 1'b0, "R2 short glitch ignored", int'({hs_en, ls_en}), 1);

      // R5: off request drops the enable on the edge after acceptance
      cmd = 2'b00;
      repeat (DGL) @(negedge clk);
      check(ls_en == 1'b1, "R5 enable before acceptance", int'(ls_en), 1);
      @(negedge clk);
      check(ls_en == 1'b0 && ls_peak == 1'b1, "R5 R7 enable drop at once", int'({ls_en, ls_peak}), 1);
      hold(2'b00, 30);

      // R10: cut a turn-on window short
      cmd = 2'b10;
      while (!hs_en) @(negedge clk);
      @(negedge clk);
      @(negedge clk);
      w0 = we_cnt;
      hold(2'b00, 40);
      check((we_cnt - w0) == 1, "R10 only the turn-off window flagged", we_cnt - w0, 1);

      // pseudo-random command stream
      lf = 16'hACE1;
      for (int i = 0; i < 150; i++) begin
         int len;
         lf  = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
         len = 1 + int'(lf[9:4]) % 45;
         hold(lf[1:0], len);
      end
      hold(2'b00, 40);

      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
   end

endmodule